// File: doc/BRIEF.md
# Fractional UART Baud-Rate Generator

This block derives bit timing for an asynchronous serial link from a faster input clock. The ratio between that clock and the baud rate is usually not a whole number. An integer prescaler sets the base period. Modulation then stretches selected periods by one input clock, so that the long-run average lands close to the ideal ratio. The block emits a one-cycle `bit_tick` at the bit rate. In oversampling mode it also emits a one-cycle `sample_tick` at sixteen times the bit rate.

There are two modes, chosen by bit 0 of the control byte.

- **Direct mode:** the prescaler sets the bit period. A 3-bit eighths value lengthens that many bits out of every eight.
- **Oversampling mode:** the prescaler sets the sample period. A 4-bit sixteenths value lengthens that many sample periods out of every sixteen. The 3-bit value can still add one more clock to selected bits.

The lengthened periods are spread evenly over the pattern. Dropping the enable restarts all timing, which a receiver uses to line up on a start edge.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `bit_tick` and `sample_tick` are 0, whatever the other inputs are.
- R2: With `mod_ctrl[0]`=0 (direct mode), bit k after enable (k counted modulo 8 from 0) lasts P + e cycles. Here P is the prescale value, S = `mod_ctrl[3:1]`, and e = 1 when ((k·S) mod 8) + S ≥ 8, else 0. `sample_tick` stays 0 in this mode.
- R3: With `mod_ctrl[0]`=1 (oversampling mode), sample period t after enable (t counted modulo 16 from 0) lasts P + f cycles, plus the R4 addition. Here F = `mod_ctrl[7:4]`, and f = 1 when ((t·F) mod 16) + F ≥ 16.
- R4: In oversampling mode, `bit_tick` is asserted together with every 16th `sample_tick`. The 16th sample period of bit k is lengthened by the R2 term e, computed from S and k.
- R5: Over any aligned run of 8 bits in direct mode, the bit periods sum to 8·P + S. Over 16 sample periods in oversampling mode, the sample periods sum to 16·P + F. No single period differs from P (direct mode) or 16·P (bit level) by more than the modulation allows.
- R6: When `en` is low at a clock edge, both ticks are 0 in the next cycle, and the period and position counters restart. The first tick after `en` rises comes P cycles after the first enabled edge (position 0 carries no extra cycle).
- R7: A prescale value of 0 behaves exactly like a prescale value of 1.
- R8: In direct mode, `mod_ctrl[7:4]` has no effect on the tick timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low clears and realigns all timing |
| prescale | input | PRESCALE_W | Integer divisor (bit period or sample period) |
| mod_ctrl | input | 8 | [7:4] sixteenths stage, [3:1] eighths stage, [0] oversampling enable |
| bit_tick | output | 1 | One-cycle strobe per bit period |
| sample_tick | output | 1 | One-cycle strobe per sample period in oversampling mode |

## Verification
The assertions assume that `prescale` and `mod_ctrl` stay constant while `en` is high, and for the cycle after it drops. Under that assumption, each measured gap between ticks can be tied to a single configuration. The stimulus changes the configuration only after `en` has been low for two edges, then raises `en` again. Every period measurement therefore starts from a clean restart at position 0.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int S1_W = 4;
  localparam int S2_W = 3;

  typedef struct packed {
    logic [S1_W-1:0] stage1;
    logic [S2_W-1:0] stage2;
    logic            os_en;
  } mod_ctrl_t;

  // Even spreading: slot pos is lengthened when the running quotient steps.
  function automatic logic spread_hit(input int val, input int pos, input int slots);
    return (((pos + 1) * val) / slots) != ((pos * val) / slots);
  endfunction
endpackage

// File: rtl/fbg_pattern.sv
module fbg_pattern #(
  parameter int VW = 3
) (
  input  logic [VW-1:0] val,
  input  logic [VW-1:0] pos,
  output logic          hit
);
  localparam int SLOTS = 1 << VW;

  logic [SLOTS-1:0] rows [SLOTS];

  generate
    for (genvar v = 0; v < SLOTS; v++) begin : g_row
      for (genvar p = 0; p < SLOTS; p++) begin : g_col
        assign rows[v][p] = fbg_pkg::spread_hit(v, p, SLOTS);
      end
    end
  endgenerate

  assign hit = rows[val][pos];
endmodule

// File: rtl/fbg_counter.sv
module fbg_counter #(
  parameter int CW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic          term
);
  logic [CW-1:0] cnt;

  assign term = run && (cnt == len - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || term) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fbg_slot.sv
module fbg_slot #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         adv,
  output logic [W-1:0] pos
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pos <= '0;
    else if (!run) pos <= '0;
    else if (adv)  pos <= pos + 1'b1;
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int PRESCALE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [PRESCALE_W-1:0] prescale,
  input  logic [7:0]            mod_ctrl,
  output logic                  bit_tick,
  output logic                  sample_tick
);
  import fbg_pkg::*;

  localparam int CW = PRESCALE_W + 2;

  mod_ctrl_t             ctl;
  logic [PRESCALE_W-1:0] presc_eff;
  logic [S1_W-1:0]       tick_pos;
  logic [S2_W-1:0]       bit_pos;
  logic                  tick_last;
  logic                  stage1_hit;
  logic                  stage2_hit;
  logic [1:0]            extra;
  logic [CW-1:0]         period_len;
  logic                  term;
  logic                  tick_adv;
  logic                  bit_adv;

  assign ctl       = mod_ctrl_t'(mod_ctrl);
  assign presc_eff = (prescale == '0) ? PRESCALE_W'(1) : prescale;
  assign tick_last = &tick_pos;

  fbg_pattern #(.VW(S1_W)) u_stage1 (
    .val(ctl.stage1), .pos(tick_pos), .hit(stage1_hit)
  );

  fbg_pattern #(.VW(S2_W)) u_stage2 (
    .val(ctl.stage2), .pos(bit_pos), .hit(stage2_hit)
  );

  always_comb begin
    if (ctl.os_en) extra = {1'b0, stage1_hit} + {1'b0, tick_last & stage2_hit};
    else           extra = {1'b0, stage2_hit};
  end

  assign period_len = CW'(presc_eff) + CW'(extra);

  fbg_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(en), .len(period_len), .term(term)
  );

  assign tick_adv = term & ctl.os_en;
  assign bit_adv  = ctl.os_en ? (term & tick_last) : term;

  fbg_slot #(.W(S1_W)) u_tick_slot (
    .clk(clk), .rst_n(rst_n), .run(en), .adv(tick_adv), .pos(tick_pos)
  );

  fbg_slot #(.W(S2_W)) u_bit_slot (
    .clk(clk), .rst_n(rst_n), .run(en), .adv(bit_adv), .pos(bit_pos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_tick    <= 1'b0;
      sample_tick <= 1'b0;
    end else begin
      bit_tick    <= en & bit_adv;
      sample_tick <= en & tick_adv;
    end
  end
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [PW-1:0] prescale,
  input logic [7:0]    mod_ctrl,
  input logic          bit_tick,
  input logic          sample_tick
);
  localparam int GW = PW + 4;

  logic          os;
  logic [GW-1:0] p_eff;
  logic [GW-1:0] bgap;
  logic [GW-1:0] sgap;
  logic [4:0]    scnt;

  assign os    = mod_ctrl[0];
  assign p_eff = (prescale == '0) ? GW'(1) : GW'(prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bgap <= '0;
      sgap <= '0;
      scnt <= '0;
    end else if (!en) begin
      bgap <= '0;
      sgap <= '0;
      scnt <= '0;
    end else begin
      bgap <= bit_tick ? GW'(1) : bgap + 1'b1;
      sgap <= sample_tick ? GW'(1) : sgap + 1'b1;
      if (bit_tick)         scnt <= '0;
      else if (sample_tick) scnt <= scnt + 1'b1;
    end
  end

  // R1 is covered by the reset-disabled properties and the bench reset check.
  p_en_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bit_tick && !sample_tick));

  // R7: p_eff maps prescale 0 onto 1.
  p_lf_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !os) |-> (bgap >= p_eff && bgap <= p_eff + 1'b1));

  p_lf_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !os) |-> !sample_tick);

  p_os_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && os) |-> (sgap >= p_eff && sgap <= p_eff + 2'd2));

  p_os_bit_on_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && os) |-> sample_tick);

  p_os_sixteen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && os) |-> (scnt == 5'd15));
endmodule

bind frac_baud_gen fbg_checker #(.PW(PRESCALE_W)) u_fbg_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .prescale(prescale),
  .mod_ctrl(mod_ctrl), .bit_tick(bit_tick), .sample_tick(sample_tick)
);

// File: tb/sim_frac_baud_gen.sv
`timescale 1ns/1ps
module sim_frac_baud_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] prescale = 16'd1;
  logic [7:0]  mod_ctrl = 8'd0;
  logic        bit_tick;
  logic        sample_tick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int last_b = 0;
  int last_s = 0;
  int bq[$];
  int sq[$];
  bit done = 0;

  int m_cnt, m_t, m_b;
  bit m_bit, m_smp;

  frac_baud_gen u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .prescale(prescale),
    .mod_ctrl(mod_ctrl), .bit_tick(bit_tick), .sample_tick(sample_tick)
  );

  always #2.5 clk = ~clk;

  function automatic int xtra(int v, int idx, int slots);
    return (((idx * v) % slots) + v >= slots) ? 1 : 0;
  endfunction

  function automatic int model_len();
    int p = (prescale == 0) ? 1 : int'(prescale);
    int f = int'(mod_ctrl[7:4]);
    int s = int'(mod_ctrl[3:1]);
    if (mod_ctrl[0])
      return p + xtra(f, m_t, 16) + ((m_t == 15) ? xtra(s, m_b, 8) : 0);
    return p + xtra(s, m_b, 8);
  endfunction

  // Behavioural reference: count cycles into the current period.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      m_cnt = 0; m_t = 0; m_b = 0; m_bit = 0; m_smp = 0;
    end else begin
      m_bit = 0; m_smp = 0;
      m_cnt++;
      if (m_cnt >= model_len()) begin
        m_cnt = 0;
        if (mod_ctrl[0]) begin
          m_smp = 1;
          if (m_t == 15) begin m_t = 0; m_bit = 1; m_b = (m_b + 1) % 8; end
          else m_t++;
        end else begin
          m_bit = 1; m_b = (m_b + 1) % 8;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (bit_tick)    begin bq.push_back(cyc - last_b); last_b = cyc; end
    if (sample_tick) begin sq.push_back(cyc - last_s); last_s = cyc; end
    if (rst_n) begin
      chk(bit_tick === m_bit, mod_ctrl[0] ? "R4" : "R2", "bit_tick vs model",
          int'(bit_tick), int'(m_bit));
      chk(sample_tick === m_smp, "R3", "sample_tick vs model",
          int'(sample_tick), int'(m_smp));
    end
  end

  task automatic run_cfg(input int p, input int c, input int nb);
    @(posedge clk); #1 en = 1'b0;
    repeat (2) @(posedge clk);
    #1 prescale = 16'(p); mod_ctrl = 8'(c);
    bq.delete(); sq.delete();
    last_b = cyc + 1; last_s = cyc + 1;
    en = 1'b1;
    while (bq.size() < nb) @(posedge clk);
    #1 en = 1'b0;
  endtask

  function automatic int qsum(ref int q[$], input int n);
    int s = 0;
    for (int i = 0; i < n; i++) s += q[i];
    return s;
  endfunction

  function automatic int qcount(ref int q[$], input int n, input int v);
    int s = 0;
    for (int i = 0; i < n; i++) if (q[i] == v) s++;
    return s;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset holds ticks low even with en high
    en = 1'b1; prescale = 16'd1;
    repeat (4) @(negedge clk);
    chk(!bit_tick && !sample_tick, "R1", "ticks in reset",
        int'(bit_tick | sample_tick), 0);
    @(posedge clk); #1 en = 1'b0; rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R2 R5: 9 + 1/8
    run_cfg(9, 8'h02, 8);
    chk(qsum(bq, 8) == 73, "R5", "8-bit sum p9 s1", qsum(bq, 8), 73);
    chk(qcount(bq, 8, 10) == 1 && qcount(bq, 8, 9) == 7, "R2", "long bits p9 s1",
        qcount(bq, 8, 10), 1);
    chk(bq[7] == 10, "R2", "long bit at index 7", bq[7], 10);

    // R2 R5: 13 + 5/8
    run_cfg(13, 8'h0A, 8);
    chk(qsum(bq, 8) == 109, "R5", "8-bit sum p13 s5", qsum(bq, 8), 109);
    chk(qcount(bq, 8, 14) == 5, "R2", "long bits p13 s5", qcount(bq, 8, 14), 5);

    // R8: first stage ignored in direct mode
    run_cfg(9, 8'hF2, 8);
    chk(qsum(bq, 8) == 73, "R8", "sum with stage1=15", qsum(bq, 8), 73);
    chk(sq.size() == 0, "R2", "no sample ticks in direct mode", sq.size(), 0);

    // R3 R4 R5: oversampling 6 + 13/16
    run_cfg(6, 8'hD1, 4);
    chk(qcount(bq, 4, 109) == 4, "R4", "bit periods p6 f13", bq[0], 109);
    chk(sq.size() == 64, "R4", "sample ticks per 4 bits", sq.size(), 64);
    chk(qsum(sq, 16) == 109, "R5", "16-sample sum", qsum(sq, 16), 109);
    chk(qcount(sq, 16, 7) == 13 && qcount(sq, 16, 6) == 3, "R3", "long samples",
        qcount(sq, 16, 7), 13);

    // R4: second stage on top of first
    run_cfg(6, 8'hDB, 8);
    chk(qsum(bq, 8) == 877, "R4", "8-bit sum f13 s5", qsum(bq, 8), 877);
    chk(qcount(bq, 8, 110) == 5, "R4", "bits with stage2 extra", qcount(bq, 8, 110), 5);

    // R7: prescale 0 acts as 1
    run_cfg(0, 8'h00, 8);
    chk(qcount(bq, 8, 1) == 8, "R7", "direct gaps with prescale 0", qcount(bq, 8, 1), 8);
    run_cfg(0, 8'h01, 2);
    chk(qcount(bq, 2, 16) == 2, "R7", "os bit gaps with prescale 0", bq[0], 16);
    chk(qcount(sq, 32, 1) == 32, "R7", "os sample gaps with prescale 0",
        qcount(sq, 32, 1), 32);

    // R6: enable realigns timing
    run_cfg(20, 8'h00, 1);
    chk(bq[0] == 20, "R6", "first gap after enable", bq[0], 20);
    @(posedge clk); #1 bq.delete(); en = 1'b1;
    repeat (15) @(posedge clk);
    #1 en = 1'b0;
    chk(bq.size() == 0, "R6", "no tick before period ends", bq.size(), 0);
    @(negedge clk);
    chk(!bit_tick, "R6", "tick low after en drop", int'(bit_tick), 0);
    @(posedge clk); #1 last_b = cyc + 1; en = 1'b1;
    while (bq.size() < 1) @(posedge clk);
    chk(bq[0] == 20, "R6", "gap after realign", bq[0], 20);
    #1 en = 1'b0;
    repeat (3) @(posedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule